// File: doc/BRIEF.md
# SPI Master Shift Core

This block is the serial engine of an SPI master. It pulls transmit words from an external output FIFO, shifts each one out on MOSI with the most significant bit first, and captures the same number of bits from MISO. Each received word goes to an external input FIFO, right-justified in a 32-bit field. The word length is programmable from 4 to 32 bits. An external clock-enable strobe sets the bit rate: every strobe is one half period of the serial clock.

Configuration arrives on static input vectors. These select the word length, the sampling order, the idle level of the serial clock, an internal loopback path and a high-speed input retiming stage. A packed chip-select control vector either drives each of the four active-low select lines to a level set by software, or lets the core assert one selected line for the length of each word. When the engine is enabled but has no word to send, it holds the serial clock idle and reports a one-cycle underrun event. It does not shift out stale data.

Top module: `spi_shift_core`

## Requirements
- R1: During and right after synchronous reset, tx_pop, rx_push and underrun are low, mosi is low, every cs_n line is high, and sclk equals cfg_clk_idle_high.
- R2: cfg_len holds the bit count minus one (N = cfg_len+1, legal 4..32). A word takes exactly 2N strobes of bit_tick. sclk toggles on each strobe, and rx_push is high for exactly one cycle, in the cycle after the edge that took the last strobe.
- R3: The transmit word is right-justified in tx_data (bits N-1:0). MOSI carries it most significant bit first, and bit N-1 is on mosi as soon as the word is loaded.
- R4: With cfg_in_first=1, even strobes (counting from 0) sample and odd strobes move MOSI to the next bit. With cfg_in_first=0, even strobes move MOSI (except strobe 0) and odd strobes sample.
- R5: rx_data holds the N received bits right-justified with zeros above them. The first bit received is the most significant.
- R6: With cfg_loopback=1, the receive path takes the core's own MOSI and ignores miso, so rx_data equals the transmitted word.
- R7: With cfg_hs_mode=1 and loopback off, miso passes through one extra clk register before it is sampled. With loopback on, cfg_hs_mode has no effect.
- R8: Outside a word, sclk rests at cfg_clk_idle_high, and it is back at that level when rx_push rises.
- R9: When cfg_cs_ctrl bit 0 (force) is 1 and bit 1 (auto) is 0, cs_n[k] follows cfg_cs_ctrl bit 4+k one cycle later, both during words and between them.
- R10: Otherwise only the line indexed by cfg_cs_ctrl[3:2] goes low. It goes low in the cycle tx_pop is high and stays low until rx_push; all other lines stay high.
- R11: A word is loaded only when run is high and tx_empty is low. tx_pop is a one-cycle pulse in the cycle after the load, and bit_tick strobes outside a word have no effect on sclk.
- R12: When run is high, no word is in progress and tx_empty is high, underrun pulses once for each stall, no pop occurs, and sclk stays at its idle level.
- R13: With run low, no word is loaded and no underrun is reported, even if tx_empty is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Half-bit clock-enable strobe |
| run | input | 1 | Engine enable |
| cfg_len | input | 5 | Bits per word minus one |
| cfg_in_first | input | 1 | Sample on the leading edge (phase 0) when set |
| cfg_loopback | input | 1 | Route MOSI internally to the receive path |
| cfg_hs_mode | input | 1 | Extra MISO retiming stage; ignored under loopback |
| cfg_clk_idle_high | input | 1 | Idle level of sclk |
| cfg_cs_ctrl | input | 8 | [0] force, [1] auto, [3:2] select index, [7:4] per-line levels |
| tx_empty | input | 1 | Output FIFO has no word |
| tx_data | input | 32 | Head word of the output FIFO, right-justified |
| tx_pop | output | 1 | Head word taken |
| rx_push | output | 1 | rx_data holds a new word |
| rx_data | output | 32 | Received word, right-justified |
| underrun | output | 1 | One-cycle stall event |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the core with its default 32-bit data path and four select lines. It sweeps every legal word length from 4 to the full 32 bits, which drives the half-bit counter to its maximum of 63 and fills the whole receive register. Every length runs under both sampling orders, with and without high-speed retiming, and with alternating idle levels and select indexes. Loopback is run at several lengths with retiming requested to confirm that it is ignored. Manual select levels, the run gate and underrun pulses are tested directly.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;

  localparam int CS_FORCE_BIT = 0;
  localparam int CS_AUTO_BIT  = 1;
  localparam int CS_SEL_LSB   = 2;
endpackage

// File: rtl/spi_sample_path.sv
module spi_sample_path (
  input  logic clk,
  input  logic rst,
  input  logic loopback,
  input  logic hs_mode,
  input  logic miso,
  input  logic mosi_loop,
  output logic sample_bit
);
  logic miso_q;
  logic hs_eff;

  always_ff @(posedge clk) begin
    if (rst) miso_q <= 1'b0;
    else     miso_q <= miso;
  end

  always_comb begin
    hs_eff = hs_mode && !loopback;
    if (loopback)    sample_bit = mosi_loop;
    else if (hs_eff) sample_bit = miso_q;
    else             sample_bit = miso;
  end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
  import spi_core_pkg::*;
#(
  parameter  int NUM_CS  = 4,
  localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LVL_LSB = CS_SEL_LSB + SEL_W,
  localparam int CTRL_W  = LVL_LSB + NUM_CS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              busy_nxt,
  output logic [NUM_CS-1:0] cs_n
);
  logic             manual;
  logic [SEL_W-1:0] sel;

  assign manual = ctrl[CS_FORCE_BIT] && !ctrl[CS_AUTO_BIT];
  assign sel    = ctrl[CS_SEL_LSB +: SEL_W];

  for (genvar k = 0; k < NUM_CS; k++) begin : g_line
    logic cs_q;
    always_ff @(posedge clk) begin
      if (rst)         cs_q <= 1'b1;
      else if (manual) cs_q <= ctrl[LVL_LSB + k];
      else             cs_q <= !(busy_nxt && (sel == SEL_W'(k)));
    end
    assign cs_n[k] = cs_q;
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_core_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int HALF_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              run,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_in_first,
  input  logic              cfg_clk_idle_high,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sample_bit,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              underrun,
  output logic              sclk,
  output logic              mosi,
  output logic              busy_nxt
);
  eng_state_t        state_q;
  logic [HALF_W-1:0] half_q;
  logic [LEN_W-1:0]  len_q;
  logic              first_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt, rxd_q;
  logic              mosi_q, sclk_q, pop_q, push_q, urun_q, stall_q;
  logic              in_shift, load, last_half, sample_now, step;

  always_comb begin
    in_shift   = (state_q == ST_SHIFT);
    load       = (state_q == ST_IDLE) && run && !tx_empty;
    last_half  = (half_q == {len_q, 1'b1});
    sample_now = first_q ? !half_q[0] : half_q[0];
    step       = in_shift && bit_tick;
    rx_nxt     = sample_now ? {rx_sh[DATA_W-2:0], sample_bit} : rx_sh;
    busy_nxt   = load || (in_shift && !(step && last_half));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rxd_q   <= '0;
      mosi_q  <= 1'b0;
      sclk_q  <= cfg_clk_idle_high;
      pop_q   <= 1'b0;
      push_q  <= 1'b0;
      urun_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      pop_q  <= load;
      push_q <= 1'b0;
      urun_q <= 1'b0;
      if (!in_shift) begin
        sclk_q <= cfg_clk_idle_high;
        if (load) begin
          state_q <= ST_SHIFT;
          half_q  <= '0;
          len_q   <= cfg_len;
          first_q <= cfg_in_first;
          tx_sh   <= tx_data;
          rx_sh   <= '0;
          mosi_q  <= tx_data[cfg_len];
          stall_q <= 1'b0;
        end else if (run && tx_empty && !stall_q) begin
          urun_q  <= 1'b1;
          stall_q <= 1'b1;
        end else if (!run) begin
          stall_q <= 1'b0;
        end
      end else if (step) begin
        sclk_q <= !sclk_q;
        half_q <= half_q + 1'b1;
        rx_sh  <= rx_nxt;
        if (!sample_now && (half_q != '0)) begin
          tx_sh  <= tx_sh << 1;
          mosi_q <= tx_sh[len_q - 1'b1];
        end
        if (last_half) begin
          state_q <= ST_IDLE;
          push_q  <= 1'b1;
          rxd_q   <= rx_nxt;
        end
      end
    end
  end

  assign tx_pop   = pop_q;
  assign rx_push  = push_q;
  assign rx_data  = rxd_q;
  assign underrun = urun_q;
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_core_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NUM_CS = 4,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CTRL_W = CS_SEL_LSB + SEL_W + NUM_CS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              run,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_in_first,
  input  logic              cfg_loopback,
  input  logic              cfg_hs_mode,
  input  logic              cfg_clk_idle_high,
  input  logic [CTRL_W-1:0] cfg_cs_ctrl,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              underrun,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic sample_bit;
  logic mosi_int;
  logic busy_nxt;

  spi_sample_path u_sample (
    .clk       (clk),
    .rst       (rst),
    .loopback  (cfg_loopback),
    .hs_mode   (cfg_hs_mode),
    .miso      (miso),
    .mosi_loop (mosi_int),
    .sample_bit(sample_bit)
  );

  spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk              (clk),
    .rst              (rst),
    .bit_tick         (bit_tick),
    .run              (run),
    .cfg_len          (cfg_len),
    .cfg_in_first     (cfg_in_first),
    .cfg_clk_idle_high(cfg_clk_idle_high),
    .tx_empty         (tx_empty),
    .tx_data          (tx_data),
    .sample_bit       (sample_bit),
    .tx_pop           (tx_pop),
    .rx_push          (rx_push),
    .rx_data          (rx_data),
    .underrun         (underrun),
    .sclk             (sclk),
    .mosi             (mosi_int),
    .busy_nxt         (busy_nxt)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (cfg_cs_ctrl),
    .busy_nxt(busy_nxt),
    .cs_n    (cs_n)
  );

  assign mosi = mosi_int;
endmodule

// File: rtl/spi_shift_core_chk.sv
module spi_shift_core_chk
  import spi_core_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int NUM_CS  = 4,
  localparam int LEN_W   = $clog2(DATA_W),
  localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LVL_LSB = CS_SEL_LSB + SEL_W,
  localparam int CTRL_W  = LVL_LSB + NUM_CS
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              tx_empty,
  input logic              tx_pop,
  input logic              rx_push,
  input logic [DATA_W-1:0] rx_data,
  input logic              underrun,
  input logic              sclk,
  input logic [LEN_W-1:0]  cfg_len,
  input logic              cfg_clk_idle_high,
  input logic [CTRL_W-1:0] cfg_cs_ctrl,
  input logic [NUM_CS-1:0] cs_n
);
  logic manual;
  assign manual = cfg_cs_ctrl[CS_FORCE_BIT] && !cfg_cs_ctrl[CS_AUTO_BIT];

  a_r2_push_single: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);

  a_r11_pop_single: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);

  a_r11_pop_needs_word: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(run && !tx_empty));

  a_r12_underrun_single: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  a_r12_underrun_idle: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (!tx_pop && (sclk == $past(cfg_clk_idle_high))));

  a_r8_end_idle: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (sclk == $past(cfg_clk_idle_high)));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> ((rx_data >> (32'($past(cfg_len)) + 32'd1)) == '0));

  a_r9_manual_level: assert property (@(posedge clk) disable iff (rst)
    manual |=> (!manual || (cs_n == $past(cfg_cs_ctrl[LVL_LSB +: NUM_CS]))));

  a_r10_single_select: assert property (@(posedge clk) disable iff (rst)
    !manual |=> (manual || ($countones(~cs_n) <= 1)));

  a_r10_pop_selects: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !manual && $past(!manual)) |->
      (cs_n == ~(NUM_CS'(1) << $past(cfg_cs_ctrl[CS_SEL_LSB +: SEL_W]))));
endmodule

bind spi_shift_core spi_shift_core_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .run              (run),
  .tx_empty         (tx_empty),
  .tx_pop           (tx_pop),
  .rx_push          (rx_push),
  .rx_data          (rx_data),
  .underrun         (underrun),
  .sclk             (sclk),
  .cfg_len          (cfg_len),
  .cfg_clk_idle_high(cfg_clk_idle_high),
  .cfg_cs_ctrl      (cfg_cs_ctrl),
  .cs_n             (cs_n)
);

// File: tb/spi_shift_core_test.sv
module spi_shift_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        run = 1'b0;
  logic [4:0]  cfg_len = 5'd7;
  logic        cfg_in_first = 1'b1;
  logic        cfg_loopback = 1'b0;
  logic        cfg_hs_mode = 1'b0;
  logic        cfg_clk_idle_high = 1'b1;
  logic [7:0]  cfg_cs_ctrl = 8'h02;
  logic        tx_empty = 1'b1;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_push, underrun, sclk, mosi;
  logic [31:0] rx_data;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = !clk;

  spi_shift_core uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .run(run),
    .cfg_len(cfg_len), .cfg_in_first(cfg_in_first), .cfg_loopback(cfg_loopback),
    .cfg_hs_mode(cfg_hs_mode), .cfg_clk_idle_high(cfg_clk_idle_high),
    .cfg_cs_ctrl(cfg_cs_ctrl), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .underrun(underrun),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(input int n, input bit inf, input bit lb, input bit hs,
                          input bit idle, input logic [7:0] ctrl,
                          input logic [31:0] w, input logic [31:0] s);
    logic [31:0] m, exp_rx;
    logic [3:0]  cs_busy, cs_after;
    bit          manual, got;
    int          sclk_err, mosi_err, push_err, cs_err, idx;
    manual   = ctrl[0] && !ctrl[1];
    cs_busy  = manual ? ctrl[7:4] : ~(4'b0001 << ctrl[3:2]);
    cs_after = manual ? ctrl[7:4] : 4'hF;
    m        = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    cfg_len = 5'(n - 1); cfg_in_first = inf; cfg_loopback = lb; cfg_hs_mode = hs;
    cfg_clk_idle_high = idle; cfg_cs_ctrl = ctrl; miso = 1'b0;
    tx_data = w; tx_empty = 1'b0; run = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 10 && !got; i++) begin
      @(negedge clk);
      if (tx_pop) got = 1'b1;
    end
    chk(got, "R11 pop after load", {31'b0, got}, 32'd1);
    tx_empty = 1'b1;
    chk(mosi == w[n-1], "R3 first bit on mosi at load", {31'b0, mosi}, {31'b0, w[n-1]});
    chk(sclk == idle, "R8 sclk idle before first strobe", {31'b0, sclk}, {31'b0, idle});
    chk(cs_n == cs_busy, "R9/R10 select lines during word", {28'b0, cs_n}, {28'b0, cs_busy});
    sclk_err = 0; mosi_err = 0; push_err = 0; cs_err = 0;
    for (int t = 0; t < 2 * n; t++) begin
      bit_tick = 1'b1;
      miso = s[n - 1 - t / 2];
      @(negedge clk);
      if (sclk != (idle ^ !t[0])) sclk_err++;
      idx = inf ? (t + 1) / 2 : t / 2;
      if (idx < n && mosi != w[n - 1 - idx]) mosi_err++;
      if (rx_push != (t == 2 * n - 1)) push_err++;
      if (t < 2 * n - 1 && cs_n != cs_busy) cs_err++;
    end
    bit_tick = 1'b0;
    chk(sclk_err == 0, "R2 sclk toggles once per strobe", 32'(sclk_err), 32'd0);
    chk(mosi_err == 0, "R4 mosi order for sampling mode", 32'(mosi_err), 32'd0);
    chk(push_err == 0, "R2 single push after last strobe", 32'(push_err), 32'd0);
    chk(cs_err == 0, "R10 select held through word", 32'(cs_err), 32'd0);
    if (lb)              exp_rx = w & m;
    else if (hs && inf)  exp_rx = (s & m) >> 1;
    else                 exp_rx = s & m;
    chk(rx_data == exp_rx,
        lb ? "R6 loopback word" : (hs ? "R7 retimed receive word" : "R5 received word"),
        rx_data, exp_rx);
    chk(cs_n == cs_after, "R10 select released at word end", {28'b0, cs_n}, {28'b0, cs_after});
    @(negedge clk);
    chk(underrun == 1'b1, "R12 underrun when FIFO empty", {31'b0, underrun}, 32'd1);
    @(negedge clk);
    chk(underrun == 1'b0 && sclk == idle, "R12 single underrun, clock idle",
        {30'b0, underrun, sclk}, {31'b0, idle});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pops, uruns;
    logic [31:0] w, s;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1 && mosi == 1'b0 && cs_n == 4'hF && !tx_pop && !rx_push && !underrun,
        "R1 reset state", {26'b0, sclk, mosi, cs_n}, {26'b0, 1'b1, 1'b0, 4'hF});
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1 && cs_n == 4'hF && !tx_pop && !underrun, "R1 state after reset",
        {27'b0, sclk, cs_n}, {27'b0, 1'b1, 4'hF});

    // R13: run low blocks loading even with a word waiting
    tx_empty = 1'b0; tx_data = 32'h5A; pops = 0; uruns = 0;
    for (int i = 0; i < 8; i++) begin
      bit_tick = i[0];
      @(negedge clk);
      if (tx_pop) pops++;
      if (underrun) uruns++;
    end
    chk(pops == 0 && uruns == 0, "R13 no load with run low", 32'(pops + uruns), 32'd0);

    // R11/R12: strobes while idle, FIFO empty, run high
    tx_empty = 1'b1; run = 1'b1; pops = 0; uruns = 0;
    for (int i = 0; i < 8; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      if (tx_pop) pops++;
      if (underrun) uruns++;
      if (sclk != cfg_clk_idle_high) pops += 100;
    end
    bit_tick = 1'b0;
    chk(pops == 0, "R11 idle strobes ignored, no pop", 32'(pops), 32'd0);
    chk(uruns == 1, "R12 one underrun per stall", 32'(uruns), 32'd1);

    // sweep all lengths, both sampling orders, retiming on and off
    for (int n = 4; n <= 32; n++) begin
      for (int mode = 0; mode < 4; mode++) begin
        w = 32'hA5C3_96E1 * 32'(n) + 32'(mode) * 32'h1357_9BDF;
        s = ~w ^ (32'(n) << 3);
        run_word(n, mode[0], 1'b0, mode[1], n[0] ^ mode[0],
                 {4'b0000, 2'(n + mode), 2'b10}, w, s);
      end
    end

    // loopback with retiming requested (must be ignored)
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 2; f++) begin
        int n;
        n = (k == 0) ? 4 : (k == 1) ? 8 : (k == 2) ? 13 : 32;
        w = 32'h3C96_E1A5 ^ (32'(n) * 32'h0101_0101);
        run_word(n, f[0], 1'b1, 1'b1, f[0], {4'b0000, 2'(k), 2'b10}, w, ~w);
      end
    end

    // manual select levels (R9)
    run_word(12, 1'b1, 1'b0, 1'b0, 1'b0, {4'b1010, 2'b01, 2'b01}, 32'h0ABC, 32'h0123);
    run_word(9, 1'b0, 1'b0, 1'b0, 1'b1, {4'b0110, 2'b11, 2'b01}, 32'h01A5, 32'h015A);
    cfg_cs_ctrl = {4'b0011, 2'b00, 2'b01};
    @(negedge clk);
    @(negedge clk);
    chk(cs_n == 4'b0011, "R9 manual level update between words", {28'b0, cs_n}, 32'h3);

    run = 1'b0;
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule